// File: doc/BRIEF.md
# EDO Page-Mode DRAM Access Controller

This block sits between a simple request port and an asynchronous extended-data-out DRAM whose row and column addresses share one set of 11 address pins. A host presents single reads or writes on a valid/ready port with a 22-bit word address: the row in the upper 11 bits and the column in the lower 11 bits. The controller opens the row with RAS, strobes the column with CAS, and returns read data on a one-cycle response pulse.

When consecutive requests hit the row that is already open, RAS stays low and only CAS cycles, giving EDO page bursts. A burst closes when the next request targets a different row, when no request is waiting at the decision point, or when keeping RAS low longer would break the maximum RAS-low time. Every write is an early write: WE falls and the write data is driven one full cycle before CAS falls, so the DRAM never drives its outputs during a write. Output enable is only asserted during a read's CAS-low phase.

All DRAM timing values are parameters in nanoseconds, turned into clock counts at elaboration by rounding up against the clock period. Refresh is not scheduled here.

Top module: `edo_dram_ctrl`

## Requirements
- R1: After reset, RAS, CAS, WE and OE are high, the data bus is not driven, no response is pending and the request port is ready.
- R2: The row (request address bits 21..11) is on the address pins when RAS falls and the column (bits 10..0) is on them when CAS falls, and they address the most recently accepted request.
- R3: For a write, WE is low and the write data is driven before CAS falls, and OE stays high for the whole write.
- R4: Each read returns exactly one response pulse whose data equals the last value written to that address (or the DRAM's initial content), sampled no earlier than the latest of the RAS, CAS and column-address access times.
- R5: RAS stays low at least tRAS, stays high at least tRP, and successive RAS falls are at least tRC apart.
- R6: CAS falls at least tRCD after RAS falls, and the address pins do not change until tRAH after RAS falls.
- R7: CAS only goes low while RAS is low; each CAS-low pulse lasts at least tCAS, CAS stays high at least tCP between page accesses, and successive CAS falls in a row are at least tPC apart.
- R8: Back-to-back requests to the open row are served as one burst under a single RAS-low period.
- R9: A request to another row, or an empty request port at the decision point, closes the row; when RAS rises CAS, WE and OE are high and the data bus is released.
- R10: RAS never stays low longer than the page-mode maximum, even under an endless stream to one row.
- R11: The controller never drives the data bus while OE is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Row in bits 21..11, column in bits 10..0 |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 4 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 4 | Data returned from the DRAM |

## Verification
A wrong phase state or a mis-loaded phase counter shows up at the strobes within one RAS or CAS period: a pulse shorter than its minimum, CAS falling outside RAS, or a RAS rise with another strobe still low. A wrong read-length count makes the response carry the deliberately inverted pre-access data of the DRAM model in that same access, and a latched address or write-data slip appears as a mismatched read a few accesses later. A broken page decision appears as a wrong number of CAS pulses under one RAS-low period, or as RAS staying low past its maximum during a long single-row stream.

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
  parameter int CLK_PERIOD_NS = 8,
  parameter int ADDR_W        = 11,
  parameter int DQ_W          = 4,
  parameter int T_RC_NS       = 84,
  parameter int T_RP_NS       = 30,
  parameter int T_RAS_NS      = 50,
  parameter int T_RASP_NS     = 100000,
  parameter int T_CAS_NS      = 8,
  parameter int T_CP_NS       = 8,
  parameter int T_PC_NS       = 20,
  parameter int T_RAH_NS      = 8,
  parameter int T_RCD_NS      = 12,
  parameter int T_RAC_NS      = 50,
  parameter int T_CAC_NS      = 14,
  parameter int T_AA_NS       = 25,
  parameter int T_DH_NS       = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [2*ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]     req_wdata,
  output logic                rsp_valid,
  output logic [DQ_W-1:0]     rsp_rdata,
  output logic                dram_ras_n,
  output logic                dram_cas_n,
  output logic                dram_we_n,
  output logic                dram_oe_n,
  output logic [ADDR_W-1:0]   dram_addr,
  output logic [DQ_W-1:0]     dram_dq_out,
  output logic                dram_dq_oe,
  input  logic [DQ_W-1:0]     dram_dq_in
);

  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_RC      = ns2cyc(T_RC_NS);
  localparam int N_RP      = ns2cyc(T_RP_NS);
  localparam int N_RAS     = ns2cyc(T_RAS_NS);
  localparam int N_RASP    = ns2cyc(T_RASP_NS);
  localparam int N_CAS     = ns2cyc(T_CAS_NS);
  localparam int N_CP      = ns2cyc(T_CP_NS);
  localparam int N_PC      = ns2cyc(T_PC_NS);
  localparam int N_RAH     = ns2cyc(T_RAH_NS);
  localparam int N_RCD     = ns2cyc(T_RCD_NS);
  localparam int N_RAC     = ns2cyc(T_RAC_NS);
  localparam int N_CAC     = ns2cyc(T_CAC_NS);
  localparam int N_AA      = ns2cyc(T_AA_NS);
  localparam int N_DH      = ns2cyc(T_DH_NS);
  localparam int N_COL     = imax(1, N_RCD - N_RAH);
  localparam int WR_LEN    = imax(N_CAS, N_DH);
  localparam int RD_MAX    = imax(imax(N_CAC, N_AA), imax(N_RAC, N_CAS));
  localparam int PAGE_SPAN = RD_MAX + imax(N_CP, N_PC) + 4;
  localparam int CW        = $clog2(N_RASP + 1) + 1;
  localparam logic [CW-1:0] AGE_MAX   = '1;
  localparam logic [CW-1:0] PAGE_LIM  = CW'(N_RASP - PAGE_SPAN);

  typedef enum logic [3:0] {
    S_IDLE, S_ROW, S_ACT, S_COL, S_CASL, S_CAP, S_CASH, S_HOLD, S_PRE
  } state_t;

  state_t              st;
  logic [CW-1:0]       cnt, age, cash_q;
  logic [ADDR_W-1:0]   row_q, col_q;
  logic                wr_q;
  logic [DQ_W-1:0]     wd_q;
  int                  rd_len, low_len, cash_len, pre_tot, pre_len;

  wire [ADDR_W-1:0] req_row = req_addr[2*ADDR_W-1:ADDR_W];
  wire [ADDR_W-1:0] req_col = req_addr[ADDR_W-1:0];
  wire page_rdy = (st == S_CASH) && (cnt == '0) && (req_row == row_q) && (age < PAGE_LIM);
  wire take     = req_valid && req_ready;
  wire ras_low  = st inside {S_ACT, S_COL, S_CASL, S_CAP, S_CASH, S_HOLD};
  wire wr_phase = wr_q && (st inside {S_COL, S_CASL});

  assign req_ready   = (st == S_IDLE) || page_rdy;
  assign dram_ras_n  = !ras_low;
  assign dram_cas_n  = !(st inside {S_CASL, S_CAP});
  assign dram_we_n   = !wr_phase;
  assign dram_oe_n   = !(!wr_q && (st inside {S_CASL, S_CAP}));
  assign dram_dq_oe  = wr_phase;
  assign dram_dq_out = wd_q;
  assign dram_addr   = (st inside {S_IDLE, S_ROW, S_ACT}) ? row_q : col_q;

  always_comb begin
    rd_len   = imax(imax(N_CAC, N_AA), imax(N_RAC - (int'(age) + 1), N_CAS));
    low_len  = wr_q ? WR_LEN : rd_len;
    cash_len = imax(N_CP, N_PC - (low_len + (wr_q ? 0 : 1)));
    pre_tot  = imax(N_RP, N_RC - (int'(age) + 1));
    pre_len  = (pre_tot > 3) ? pre_tot - 3 : 0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      age       <= '0;
      cash_q    <= '0;
      row_q     <= '0;
      col_q     <= '0;
      wr_q      <= 1'b0;
      wd_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (st == S_CAP);
      if (st == S_CAP) rsp_rdata <= dram_dq_in;
      if (st == S_ROW) age <= '0;
      else if (ras_low && age != AGE_MAX) age <= age + 1'b1;
      if (take) begin
        row_q <= req_row;
        col_q <= req_col;
        wr_q  <= req_write;
        wd_q  <= req_wdata;
      end
      case (st)
        S_IDLE: if (take) st <= S_ROW;
        S_ROW: begin
          st  <= S_ACT;
          cnt <= CW'(N_RAH - 1);
        end
        S_ACT:
          if (cnt == '0) begin
            st  <= S_COL;
            cnt <= CW'(N_COL - 1);
          end else cnt <= cnt - 1'b1;
        S_COL:
          if (cnt == '0) begin
            st     <= S_CASL;
            cnt    <= CW'(low_len - 1);
            cash_q <= CW'(cash_len - 1);
          end else cnt <= cnt - 1'b1;
        S_CASL:
          if (cnt == '0) begin
            if (wr_q) begin
              st  <= S_CASH;
              cnt <= cash_q;
            end else st <= S_CAP;
          end else cnt <= cnt - 1'b1;
        S_CAP: begin
          st  <= S_CASH;
          cnt <= cash_q;
        end
        S_CASH:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (take) begin
            st  <= S_COL;
            cnt <= '0;
          end else st <= S_HOLD;
        S_HOLD:
          if (age >= CW'(N_RAS - 1)) begin
            st  <= S_PRE;
            cnt <= CW'(pre_len);
          end
        S_PRE: if (cnt == '0) st <= S_IDLE; else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_row_stable_at_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> $stable(dram_addr));
  a_r2_col_stable_at_cas: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> $stable(dram_addr));
  a_r3_early_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> ($past(!dram_we_n) && $past(dram_dq_oe)));
  a_r3_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> dram_oe_n);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r5_ras_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> $past(age) >= CW'(N_RAS - 1));
  a_r7_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);
  a_r9_precharged_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && dram_ras_n) |-> (dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe));
  a_r10_rasp_limit: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> age < CW'(N_RASP));
  a_r11_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> dram_oe_n);

endmodule

// File: tb/edo_dram_ctrl_bench.sv
`timescale 1ns/1ps
module edo_dram_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [3:0]  rsp_rdata;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [10:0] dram_addr;
  logic [3:0]  dram_dq_out;
  logic [3:0]  dram_dq_in = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  edo_dram_ctrl u_edo_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", rq, $time, act, exp);
    end
  endtask

  function automatic logic [3:0] dflt(input logic [21:0] a);
    return a[3:0] ^ a[14:11] ^ 4'h5;
  endfunction

  logic [3:0]  gold [int];
  logic [3:0]  mem  [int];
  logic [3:0]  expq [$];
  logic [21:0] last_acc;

  realtime t_ras_fall = -1000.0, t_ras_rise = -1000.0, t_cas_fall = -1000.0;
  realtime t_cas_rise = -1000.0, t_addr = 0.0, valid_at = 0.0;
  logic [10:0] row_l, col_l;
  logic [3:0]  cur;
  bit reading = 0, first_cas = 0;
  int cas_in_row = 0, last_burst = 0, ras_falls = 0;

  always @(dram_addr) begin
    if (rst_n && !dram_ras_n)
      chk(($realtime - t_ras_fall) >= 8.0, "R6 row hold", int'($realtime - t_ras_fall), 8);
    t_addr = $realtime;
  end

  always @(negedge dram_ras_n) if (rst_n) begin
    chk(($realtime - t_ras_rise) >= 30.0, "R5 tRP", int'($realtime - t_ras_rise), 30);
    chk(($realtime - t_ras_fall) >= 84.0, "R5 tRC", int'($realtime - t_ras_fall), 84);
    chk(dram_addr == last_acc[21:11], "R2 row", dram_addr, last_acc[21:11]);
    row_l = dram_addr;
    t_ras_fall = $realtime;
    cas_in_row = 0;
    first_cas = 1;
    ras_falls++;
  end

  always @(posedge dram_ras_n) if (rst_n) begin
    chk(($realtime - t_ras_fall) >= 50.0, "R5 tRAS", int'($realtime - t_ras_fall), 50);
    chk(($realtime - t_ras_fall) <= 100000.0, "R10 RAS max", int'($realtime - t_ras_fall), 100000);
    chk(dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe, "R9 strobes at close",
        {dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe}, 4'b1110);
    t_ras_rise = $realtime;
    last_burst = cas_in_row;
    reading = 0;
  end

  always @(negedge dram_cas_n) if (rst_n) begin
    chk(!dram_ras_n, "R7 CAS within RAS", dram_ras_n, 0);
    if (first_cas)
      chk(($realtime - t_ras_fall) >= 12.0, "R6 tRCD", int'($realtime - t_ras_fall), 12);
    else begin
      chk(($realtime - t_cas_rise) >= 8.0, "R7 tCP", int'($realtime - t_cas_rise), 8);
      chk(($realtime - t_cas_fall) >= 20.0, "R7 tPC", int'($realtime - t_cas_fall), 20);
    end
    first_cas = 0;
    col_l = dram_addr;
    chk({row_l, col_l} == last_acc, "R2 column", {row_l, col_l}, last_acc);
    t_cas_fall = $realtime;
    cas_in_row++;
    if (!dram_we_n) begin
      chk(dram_dq_oe && dram_oe_n, "R3 early write drive", {dram_dq_oe, dram_oe_n}, 2'b11);
      mem[int'({row_l, col_l})] = dram_dq_out;
      reading = 0;
    end else begin
      cur = mem.exists(int'({row_l, col_l})) ? mem[int'({row_l, col_l})] : dflt({row_l, col_l});
      valid_at = t_ras_fall + 50.0;
      if ($realtime + 14.0 > valid_at) valid_at = $realtime + 14.0;
      if (t_addr + 25.0 > valid_at) valid_at = t_addr + 25.0;
      reading = 1;
    end
  end

  always @(posedge dram_cas_n) if (rst_n) begin
    chk(($realtime - t_cas_fall) >= 8.0, "R7 tCAS", int'($realtime - t_cas_fall), 8);
    t_cas_rise = $realtime;
  end

  always @(posedge dram_dq_oe) if (rst_n)
    chk(dram_oe_n, "R11 no drive under OE", dram_oe_n, 1);
  always @(negedge dram_oe_n) if (rst_n)
    chk(!dram_dq_oe, "R11 OE while driving", dram_dq_oe, 0);

  always begin
    #0.5;
    dram_dq_in = (reading && $realtime >= valid_at) ? cur : ~cur;
  end

  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (expq.size() == 0) chk(0, "R4 unexpected response", 1, 0);
    else begin
      logic [3:0] e;
      e = expq.pop_front();
      chk(rsp_rdata == e, "R4 read data", rsp_rdata, e);
    end
  end

  task automatic send(input bit w, input logic [21:0] a, input logic [3:0] d);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    last_acc = a;
    if (w) gold[int'(a)] = d;
    else expq.push_back(gold.exists(int'(a)) ? gold[int'(a)] : dflt(a));
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int f0;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe && !rsp_valid && req_ready,
        "R1 reset state", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe, rsp_valid, req_ready},
        7'b1111001);
    @(negedge clk);

    // R3/R4: single write then read-back after a row change
    send(1, {11'd5, 11'd100}, 4'hA); idle(20);
    send(0, {11'd9, 11'd3}, 4'h0);   idle(20);
    send(0, {11'd5, 11'd100}, 4'h0); idle(20);
    chk(expq.size() == 0, "R4 responses drained", expq.size(), 0);

    // R8: four-access page burst on one row
    send(1, {11'd7, 11'd1}, 4'h3);
    send(1, {11'd7, 11'd2}, 4'hC);
    send(0, {11'd7, 11'd1}, 4'h0);
    send(0, {11'd7, 11'd2}, 4'h0);
    idle(20);
    chk(last_burst == 4, "R8 burst length", last_burst, 4);

    // R9: row change forces a new RAS period
    f0 = ras_falls;
    send(0, {11'd1, 11'd0}, 4'h0);
    send(0, {11'd2, 11'd0}, 4'h0);
    idle(20);
    chk(ras_falls - f0 == 2, "R9 row change", ras_falls - f0, 2);
    chk(last_burst == 1, "R9 single access rows", last_burst, 1);

    // R9: idle request port closes the row
    send(0, {11'd3, 11'd4}, 4'h0);
    idle(30);
    chk(dram_ras_n, "R9 idle close", dram_ras_n, 1);

    // random mix over four rows
    for (int i = 0; i < 250; i++) begin
      logic [21:0] a;
      a = {9'd0, 2'($urandom % 4), 11'($urandom % 16)};
      send($urandom % 2 == 1, a, 4'($urandom));
      if ($urandom % 4 == 0) idle(1 + $urandom % 3);
    end
    idle(30);
    chk(expq.size() == 0, "R4 random responses drained", expq.size(), 0);

    // R10: endless stream to one row must be split by RAS precharge
    f0 = ras_falls;
    for (int i = 0; i < 2000; i++) send(0, {11'd12, 11'($urandom % 64)}, 4'h0);
    idle(30);
    chk(ras_falls - f0 >= 2, "R10 row reopened", ras_falls - f0, 2);
    chk(expq.size() == 0, "R4 stream responses drained", expq.size(), 0);

    finish_run();
  end
endmodule